// File: doc/BRIEF.md
# Backplane Bus Arbiter

This block arbitrates ownership of a shared backplane bus among four request levels. Each level has an active-low request input and an active-low grant output. The block picks one winning level at a time and drives only that level's grant low. Several cards may share one level. Among those cards, the card nearest the arbiter wins by passing the grant along a daisy chain. That chain lies outside this block, so here it appears only as the single grant output of the level.

Two selection policies are available, chosen by a mode input. In fixed mode, level 3 always beats the lower levels. In rotating mode, the search starts at the level just above the most recent winner, which shares the bus fairly.

Handoff uses an active-low bus-busy line. The winning master answers its grant by pulling busy low. The arbiter then drops the grant, and it starts no new selection until busy is released. Requests arrive from other clock domains, so they pass through a two-flop synchroniser before selection.

Top module: `bkp_arbiter`

## Requirements
- R1: After synchronous reset, all grant lines are high (deasserted). The stored last winner is level 3, so the first rotating search begins at level 0.
- R2: Request bit i of `req_n` (low = requesting) belongs to level i and passes through two synchronising flops. A grant caused by a request change appears on the third rising edge after that change, and not on the first or second.
- R3: At most one bit of `grant_n` is low at any time, and it belongs to a level that was requesting when the grant was issued. With no requests pending, all grants stay high.
- R4: With `rr_mode` = 0 (fixed), the highest-numbered requesting level wins.
- R5: With `rr_mode` = 1 (rotating), the search starts at the level one above the last winner and wraps from 3 to 0. The first requesting level found wins. Every grant updates the last winner, in either mode.
- R6: A grant stays low, unchanged, until `busy_n` is sampled low. It is withdrawn on that same rising edge.
- R7: While `busy_n` is low, no grant is issued, whatever the requests. Selection resumes no earlier than one rising edge after `busy_n` is sampled high, and a grant can appear on the first edge at which the arbiter is idle with the bus free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst | input | 1 | Synchronous reset, active high |
| rr_mode | input | 1 | 1 = rotating policy, 0 = fixed policy (level 3 highest) |
| req_n | input | 4 | Per-level bus requests, active low, asynchronous |
| busy_n | input | 1 | Bus busy from the current master, active low |
| grant_n | output | 4 | Per-level bus grants, active low, at most one low |

## Verification
The hardest case to reach is the one where the bus is held busy by some master before any grant exists, while requests are already pending and synchronised. The stimulus pulls `busy_n` low together with the new request pattern and waits well past the synchroniser latency. It then confirms that no grant has appeared, releases busy, and expects the winner one edge later. A second case also needs care: requests that arrive while a granted master holds the bus. The bench raises every request during the busy phase and checks that the grants stay high. Both cases are swept over all sixteen request patterns in both policies. The rotating pointer is carried forward in the bench model, so each pattern meets different starting levels.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Number of request levels on the backplane
    localparam int NLVL = 4;

    // Arbiter sequencing states
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,   // bus free or waiting for busy release
        ARB_OFFER = 2'd1,   // grant driven, waiting for busy to be claimed
        ARB_OWNED = 2'd2    // busy claimed, grant withdrawn
    } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int   WIDTH   = 4,
    parameter logic RST_BIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {WIDTH{RST_BIT}};
            stage2 <= {WIDTH{RST_BIT}};
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int LEVELS = arb_pkg::NLVL,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS-1:0] req,
    input  logic              rr_mode,
    input  logic [IW-1:0]     last,
    output logic              hit,
    output logic [IW-1:0]     win
);

    logic [IW-1:0] win_fixed;
    logic [IW-1:0] win_rot;

    // Fixed policy: ascending scan, the highest index overwrites the rest
    always_comb begin
        win_fixed = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (req[i]) win_fixed = IW'(i);
        end
    end

    // Rotating policy: scan from farthest to nearest offset above last,
    // so the nearest requesting level is written last and wins
    always_comb begin
        win_rot = '0;
        for (int k = LEVELS; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % LEVELS;
            if (req[idx]) win_rot = IW'(idx);
        end
    end

    assign hit = |req;
    assign win = rr_mode ? win_rot : win_fixed;

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int LEVELS = arb_pkg::NLVL,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [IW-1:0]     win,
    input  logic              busy_n,
    output logic [LEVELS-1:0] grant,
    output logic [IW-1:0]     last
);

    localparam logic [LEVELS-1:0] ONE_HOT0 = LEVELS'(1);

    arb_state_e        state;
    logic [LEVELS-1:0] grant_q;
    logic [IW-1:0]     last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ARB_IDLE;
            grant_q <= '0;
            last_q  <= IW'(LEVELS - 1);
        end else begin
            case (state)
                ARB_IDLE: begin
                    if (hit && busy_n) begin
                        grant_q <= ONE_HOT0 << win;
                        last_q  <= win;
                        state   <= ARB_OFFER;
                    end
                end
                ARB_OFFER: begin
                    if (!busy_n) begin
                        grant_q <= '0;
                        state   <= ARB_OWNED;
                    end
                end
                ARB_OWNED: begin
                    if (busy_n) state <= ARB_IDLE;
                end
                default: begin
                    grant_q <= '0;
                    state   <= ARB_IDLE;
                end
            endcase
        end
    end

    assign grant = grant_q;
    assign last  = last_q;

endmodule

// File: rtl/bkp_arbiter.sv
module bkp_arbiter #(
    parameter int LEVELS = arb_pkg::NLVL,
    localparam int IW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic [LEVELS-1:0] req_n,
    input  logic              busy_n,
    output logic [LEVELS-1:0] grant_n
);

    logic [LEVELS-1:0] req_n_s;
    logic [LEVELS-1:0] req_act;
    logic              pick_hit;
    logic [IW-1:0]     pick_win;
    logic [IW-1:0]     last_win;
    logic [LEVELS-1:0] grant_act;

    arb_sync #(.WIDTH(LEVELS), .RST_BIT(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (req_n),
        .q_sync  (req_n_s)
    );

    assign req_act = ~req_n_s;

    arb_pick #(.LEVELS(LEVELS)) u_pick (
        .req     (req_act),
        .rr_mode (rr_mode),
        .last    (last_win),
        .hit     (pick_hit),
        .win     (pick_win)
    );

    arb_ctrl #(.LEVELS(LEVELS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .hit    (pick_hit),
        .win    (pick_win),
        .busy_n (busy_n),
        .grant  (grant_act),
        .last   (last_win)
    );

    assign grant_n = ~grant_act;

endmodule

// File: rtl/bkp_arbiter_chk.sv
module bkp_arbiter_chk #(
    parameter int LEVELS = arb_pkg::NLVL
) (
    input logic              clk,
    input logic              rst,
    input logic              rr_mode,
    input logic              busy_n,
    input logic [LEVELS-1:0] req_act,
    input logic [LEVELS-1:0] grant_n
);

    logic [LEVELS-1:0] g;
    logic [LEVELS-1:0] above_g;

    assign g       = ~grant_n;
    assign above_g = ~(g | (g - LEVELS'(1)));

    // R3: never more than one grant
    assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g));

    // R3: a fresh grant goes to a level that was requesting
    assert_grant_requester_R3: assert property (@(posedge clk) disable iff (rst)
        ((g != '0) && ($past(grant_n) == '1)) |-> (($past(req_act) & g) != '0));

    // R7: a fresh grant only when the bus was free
    assert_free_bus_R7: assert property (@(posedge clk) disable iff (rst)
        ((g != '0) && ($past(grant_n) == '1)) |-> $past(busy_n));

    // R4: in fixed mode no higher level was requesting
    assert_fixed_top_R4: assert property (@(posedge clk) disable iff (rst)
        ((g != '0) && ($past(grant_n) == '1) && !$past(rr_mode))
            |-> (($past(req_act) & above_g) == '0));

    // R6: grant held while busy not yet claimed
    assert_grant_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ((g != '0) && busy_n) |=> $stable(grant_n));

    // R6/R7: busy low leaves no grant after the edge
    assert_busy_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !busy_n |=> (grant_n == '1));

endmodule

bind bkp_arbiter bkp_arbiter_chk #(.LEVELS(LEVELS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rr_mode (rr_mode),
    .busy_n  (busy_n),
    .req_act (req_act),
    .grant_n (grant_n)
);

// File: tb/tb_bkp_arbiter.sv
module tb_bkp_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rr_mode = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       busy_n = 1'b1;
    logic [3:0] grant_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  model_last = 3;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bkp_arbiter dut (
        .clk     (clk),
        .rst     (rst),
        .rr_mode (rr_mode),
        .req_n   (req_n),
        .busy_n  (busy_n),
        .grant_n (grant_n)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: grant_n=%b expected %b (mode=%0d)", tag, act, exp, rr_mode);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Winner from the requirements: R4 fixed, R5 rotating; -1 when none
    function automatic int model_win(input logic [3:0] pat, input bit mode, input int last);
        int w;
        w = -1;
        if (!mode) begin
            for (int i = 0; i < 4; i++) if (pat[i]) w = i;
        end else begin
            for (int k = 4; k >= 1; k--) if (pat[(last + k) % 4]) w = (last + k) % 4;
        end
        return w;
    endfunction

    function automatic logic [3:0] exp_gn(input int w);
        return (w < 0) ? 4'hF : ~(4'b0001 << w);
    endfunction

    // Hold, claim, busy phase with requests, release (R6, R7, R3)
    task automatic handoff(input int w);
        waitn(4);
        check("R6 grant held before busy", grant_n, exp_gn(w));
        busy_n = 1'b0;
        waitn(1);
        check("R6 grant withdrawn on busy", grant_n, 4'hF);
        req_n = 4'h0;
        waitn(4);
        check("R7 no grant while busy", grant_n, 4'hF);
        req_n = 4'hF;
        waitn(3);
        busy_n = 1'b1;
        waitn(2);
        check("R3 idle after release", grant_n, 4'hF);
    endtask

    task automatic run_case(input logic [3:0] pat, input bit pre_busy);
        int w;
        w = model_win(pat, rr_mode, model_last);
        if (!pre_busy) begin
            req_n = ~pat;
            waitn(2);
            check("R2 no grant before third edge", grant_n, 4'hF);
            waitn(1);
            check(rr_mode ? "R5 rotating winner" : "R4 fixed winner", grant_n, exp_gn(w));
        end else begin
            busy_n = 1'b0;
            req_n  = ~pat;
            waitn(5);
            check("R7 bus held elsewhere", grant_n, 4'hF);
            busy_n = 1'b1;
            waitn(1);
            check(rr_mode ? "R7 R5 grant after release" : "R7 R4 grant after release",
                  grant_n, exp_gn(w));
        end
        if (w >= 0) begin
            model_last = w;
            handoff(w);
        end else begin
            waitn(3);
            check("R3 no request no grant", grant_n, 4'hF);
        end
        req_n  = 4'hF;
        busy_n = 1'b1;
        waitn(3);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_n = 4'hF;
        busy_n = 1'b1;
        waitn(3);
        check("R1 grants high in reset", grant_n, 4'hF);
        rst = 1'b0;
        model_last = 3;
        waitn(1);
        check("R1 grants high after reset", grant_n, 4'hF);
    endtask

    initial begin
        waitn(1);
        rr_mode = 1'b0;
        do_reset();
        // Fixed policy sweep, plain and with bus held beforehand
        for (int pass = 0; pass < 2; pass++)
            for (int p = 0; p < 16; p++) run_case(4'(p), pass == 1);

        // R1: rotating search after reset starts at level 0
        rr_mode = 1'b1;
        do_reset();
        req_n = 4'h0;
        waitn(3);
        check("R1 rotating start level 0", grant_n, 4'b1110);
        model_last = 0;
        handoff(0);
        req_n = 4'hF;
        waitn(3);

        // Rotating policy sweep, three passes so the pointer moves around
        for (int pass = 0; pass < 3; pass++)
            for (int p = 0; p < 16; p++) run_case(4'(p), pass == 1);

        // R5: the pointer is shared; a fixed grant moves it too
        rr_mode = 1'b0;
        run_case(4'b0110, 1'b0);      // fixed picks level 2
        rr_mode = 1'b1;
        run_case(4'b1111, 1'b0);      // rotating then picks level 3

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule